// File: doc/BRIEF.md
# Opcode-Steered Multiply-Add Element

This element joins a signed 8x8 multiplier, a 16-bit adder and a 16-bit result register. A 3-bit opcode picks one of eight datapath arrangements. The opcode may change on any clock cycle, and the new arrangement applies at once, with no setup step. Operands come in on plain parallel ports. The `cascade_in` port stands for the running value handed over by a neighbouring element. Because each instance decodes its own opcode, many copies can sit side by side and be steered separately.

The `result` port always shows the combinational output of the adder for the current opcode. The `reg_out` port shows the stored register. Modes that write the register do so on the rising clock edge, and only while `ce` is high. A synchronous active-high `rst` clears the register and takes priority over every opcode.

Top module: `cfg_mac_unit`

## Requirements
- R1: `a_in` and `b_in` are two's-complement values, and the product is sign-extended to 16 bits (0x80 times 0x80 gives 0x4000; 0xFF times 0x02 gives 0xFFFE). All sums wrap modulo 2^16 with no saturation.
- R2: Opcode 3'b000 drives `result` with the product in the same cycle and leaves `reg_out` unchanged.
- R3: Opcode 3'b001 drives `result` with `addend + cascade_in` in the same cycle and leaves `reg_out` unchanged.
- R4: Opcode 3'b010 drives `result` with `product + addend` in the same cycle and leaves `reg_out` unchanged.
- R5: Opcode 3'b011 shows the product on `result` and, at the next edge with `ce` high, loads the product into the register.
- R6: Opcode 3'b100 shows `addend + cascade_in` on `result` and, at the next edge with `ce` high, loads that sum into the register.
- R7: Opcode 3'b101 shows `reg_out + product` on `result` and, at the next edge with `ce` high, stores that sum in the register, wrapping past 0xFFFF.
- R8: Opcode 3'b110 drives `result` with `reg_out` and keeps the register unchanged.
- R9: Opcode 3'b111 drives `result` with zero and, at the next edge with `ce` high, clears the register.
- R10: The opcode may take a different value on every cycle. Each cycle's output and register update follow that cycle's opcode only.
- R11: When `rst` is high at a rising edge, the register becomes zero whatever the opcode or `ce` is.
- R12: When `ce` is low (and `rst` is low), the register holds for every opcode, while `result` still follows the current inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the register |
| ce | input | 1 | Register update enable |
| op | input | 3 | Mode opcode, sampled every cycle |
| a_in | input | 8 | Signed multiplier operand |
| b_in | input | 8 | Signed multiplicand operand |
| addend | input | 16 | Adder operand for add-type modes |
| cascade_in | input | 16 | Value from a neighbouring element |
| result | output | 16 | Combinational adder output |
| reg_out | output | 16 | Stored register value |

## Verification
The hardest condition to reach from the ports is a register-feedback mode acting on a chosen stored value. Examples are accumulation that wraps past 0xFFFF, or reset arriving on the same edge as a load. The register can only be seeded through the load-type modes. The stimulus therefore first uses opcode 3'b100 to write an exact value such as 0xFFFF, then applies the accumulate, hold, clear or reset cycle under test. A long random run that changes the opcode every cycle, checked against a reference model, covers the arbitrary mode-to-mode transitions.

// File: rtl/mac_pkg.sv
package mac_pkg;

    localparam int OPND_W = 8;
    localparam int WORD_W = 16;

    typedef enum logic [2:0] {
        OP_MUL    = 3'b000,
        OP_ADD    = 3'b001,
        OP_MULADD = 3'b010,
        OP_MULREG = 3'b011,
        OP_ADDREG = 3'b100,
        OP_MAC    = 3'b101,
        OP_HOLD   = 3'b110,
        OP_CLEAR  = 3'b111
    } op_e;

    // left adder input source
    typedef enum logic [1:0] {
        XS_ZERO,
        XS_PROD,
        XS_CASC
    } xsel_e;

    // right adder input source
    typedef enum logic [1:0] {
        YS_ZERO,
        YS_ADDEND,
        YS_REG
    } ysel_e;

    typedef enum logic [1:0] {
        RA_KEEP,
        RA_LOAD,
        RA_CLEAR
    } ract_e;

    typedef struct packed {
        xsel_e x_sel;
        ysel_e y_sel;
        ract_e r_act;
    } ctrl_t;

    function automatic ctrl_t decode_op(input op_e code);
        ctrl_t c;
        c = '{x_sel: XS_ZERO, y_sel: YS_ZERO, r_act: RA_KEEP};
        case (code)
            OP_MUL:    c = '{x_sel: XS_PROD, y_sel: YS_ZERO,   r_act: RA_KEEP};
            OP_ADD:    c = '{x_sel: XS_CASC, y_sel: YS_ADDEND, r_act: RA_KEEP};
            OP_MULADD: c = '{x_sel: XS_PROD, y_sel: YS_ADDEND, r_act: RA_KEEP};
            OP_MULREG: c = '{x_sel: XS_PROD, y_sel: YS_ZERO,   r_act: RA_LOAD};
            OP_ADDREG: c = '{x_sel: XS_CASC, y_sel: YS_ADDEND, r_act: RA_LOAD};
            OP_MAC:    c = '{x_sel: XS_PROD, y_sel: YS_REG,    r_act: RA_LOAD};
            OP_HOLD:   c = '{x_sel: XS_ZERO, y_sel: YS_REG,    r_act: RA_KEEP};
            OP_CLEAR:  c = '{x_sel: XS_ZERO, y_sel: YS_ZERO,   r_act: RA_CLEAR};
            default:   c = '{x_sel: XS_ZERO, y_sel: YS_ZERO,   r_act: RA_KEEP};
        endcase
        return c;
    endfunction

endpackage

// File: rtl/mac_mode_decode.sv
module mac_mode_decode
    import mac_pkg::*;
(
    input  logic [2:0] op,
    output ctrl_t      ctrl
);
    always_comb begin
        ctrl = decode_op(op_e'(op));
    end
endmodule

// File: rtl/mac_multiplier.sv
module mac_multiplier #(
    parameter int A_W = 8,
    parameter int B_W = 8,
    parameter int OUT_W = 16
) (
    input  logic [A_W-1:0]   a,
    input  logic [B_W-1:0]   b,
    output logic [OUT_W-1:0] prod
);
    localparam int P_W = A_W + B_W;

    logic [P_W-1:0] a_ext;
    logic [P_W-1:0] b_ext;
    logic [P_W-1:0] full;

    // widen both operands by their sign, so the low P_W bits are the signed product
    assign a_ext = {{B_W{a[A_W-1]}}, a};
    assign b_ext = {{A_W{b[B_W-1]}}, b};
    assign full  = a_ext * b_ext;

    generate
        if (OUT_W > P_W) begin : g_widen
            assign prod = {{(OUT_W-P_W){full[P_W-1]}}, full};
        end else begin : g_fit
            assign prod = full[OUT_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/mac_adder.sv
module mac_adder
    import mac_pkg::*;
#(
    parameter int W = 16
) (
    input  ctrl_t        ctrl,
    input  logic [W-1:0] prod,
    input  logic [W-1:0] casc,
    input  logic [W-1:0] addend,
    input  logic [W-1:0] acc,
    output logic [W-1:0] sum
);
    logic [W-1:0] x_op;
    logic [W-1:0] y_op;

    always_comb begin
        case (ctrl.x_sel)
            XS_PROD: x_op = prod;
            XS_CASC: x_op = casc;
            default: x_op = '0;
        endcase
        case (ctrl.y_sel)
            YS_ADDEND: y_op = addend;
            YS_REG:    y_op = acc;
            default:   y_op = '0;
        endcase
    end

    // modulo 2^W, carry out discarded
    assign sum = x_op + y_op;
endmodule

// File: rtl/mac_acc_reg.sv
module mac_acc_reg
    import mac_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ce,
    input  ract_e        act,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (ce) begin
            case (act)
                RA_LOAD:  q <= d;
                RA_CLEAR: q <= '0;
                default:  q <= q;
            endcase
        end
    end
endmodule

// File: rtl/cfg_mac_unit.sv
module cfg_mac_unit
    import mac_pkg::*;
#(
    parameter int A_W = OPND_W,
    parameter int B_W = OPND_W,
    parameter int W   = WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ce,
    input  logic [2:0]   op,
    input  logic [A_W-1:0] a_in,
    input  logic [B_W-1:0] b_in,
    input  logic [W-1:0] addend,
    input  logic [W-1:0] cascade_in,
    output logic [W-1:0] result,
    output logic [W-1:0] reg_out
);
    ctrl_t        ctrl;
    logic [W-1:0] prod;
    logic [W-1:0] sum;
    logic [W-1:0] acc_q;

    mac_mode_decode u_dec (
        .op   (op),
        .ctrl (ctrl)
    );

    mac_multiplier #(.A_W(A_W), .B_W(B_W), .OUT_W(W)) u_mul (
        .a    (a_in),
        .b    (b_in),
        .prod (prod)
    );

    mac_adder #(.W(W)) u_add (
        .ctrl   (ctrl),
        .prod   (prod),
        .casc   (cascade_in),
        .addend (addend),
        .acc    (acc_q),
        .sum    (sum)
    );

    mac_acc_reg #(.W(W)) u_reg (
        .clk (clk),
        .rst (rst),
        .ce  (ce),
        .act (ctrl.r_act),
        .d   (sum),
        .q   (acc_q)
    );

    assign result  = sum;
    assign reg_out = acc_q;
endmodule

// File: rtl/mac_unit_checker.sv
module mac_unit_checker
    import mac_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        ce,
    input logic [2:0]  op,
    input logic [7:0]  a_in,
    input logic [7:0]  b_in,
    input logic [15:0] addend,
    input logic [15:0] cascade_in,
    input logic [15:0] result,
    input logic [15:0] reg_out
);
    logic [15:0] chk_prod;
    logic        rst_q = 1'b0;

    assign chk_prod = {{8{a_in[7]}}, a_in} * {{8{b_in[7]}}, b_in};

    always_ff @(posedge clk) rst_q <= rst;

    // R11: a reset edge leaves the register at zero
    assert_reset_zero_R11: assert property (@(posedge clk) disable iff (rst)
        rst_q |-> reg_out == 16'h0000);

    // R12, R2, R3, R4, R8: no register write without ce or in non-writing modes
    assert_reg_stable_R12: assert property (@(posedge clk) disable iff (rst)
        (!ce || op == OP_MUL || op == OP_ADD || op == OP_MULADD || op == OP_HOLD)
        |=> $stable(reg_out));

    // R9
    assert_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (ce && op == OP_CLEAR) |=> reg_out == 16'h0000);

    // R5
    assert_load_prod_R5: assert property (@(posedge clk) disable iff (rst)
        (ce && op == OP_MULREG) |=> reg_out == $past(chk_prod));

    // R6
    assert_load_sum_R6: assert property (@(posedge clk) disable iff (rst)
        (ce && op == OP_ADDREG) |=> reg_out == $past(addend + cascade_in));

    // R7
    assert_accumulate_R7: assert property (@(posedge clk) disable iff (rst)
        (ce && op == OP_MAC) |=> reg_out == $past(reg_out + chk_prod));

    // R8
    assert_hold_view_R8: assert property (@(posedge clk) disable iff (rst)
        (op == OP_HOLD) |-> result == reg_out);

    // R4
    assert_muladd_R4: assert property (@(posedge clk) disable iff (rst)
        (op == OP_MULADD) |-> result == chk_prod + addend);
endmodule

bind cfg_mac_unit mac_unit_checker u_chk (.*);

// File: tb/tb_cfg_mac_unit.sv
module tb_cfg_mac_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ce = 1'b0;
    logic [2:0]  op = 3'b110;
    logic [7:0]  a_in = '0;
    logic [7:0]  b_in = '0;
    logic [15:0] addend = '0;
    logic [15:0] cascade_in = '0;
    logic [15:0] result;
    logic [15:0] reg_out;

    int checks = 0;
    int errors = 0;
    logic [15:0] reg_m = '0;
    bit finished = 0;

    always #4 clk = ~clk;

    cfg_mac_unit dut (
        .clk(clk), .rst(rst), .ce(ce), .op(op), .a_in(a_in), .b_in(b_in),
        .addend(addend), .cascade_in(cascade_in), .result(result), .reg_out(reg_out)
    );

    // {op, a, b, addend, cascade, expected result}
    localparam logic [66:0] VEC [8] = '{
        {3'b000, 8'h03, 8'h04, 16'h0000, 16'h0000, 16'h000C},
        {3'b000, 8'hFF, 8'h02, 16'h0000, 16'h0000, 16'hFFFE},
        {3'b000, 8'h80, 8'h80, 16'h0000, 16'h0000, 16'h4000},
        {3'b000, 8'h80, 8'h7F, 16'h0000, 16'h0000, 16'hC080},
        {3'b001, 8'h00, 8'h00, 16'hFFFF, 16'h0001, 16'h0000},
        {3'b001, 8'h00, 8'h00, 16'h1234, 16'h1111, 16'h2345},
        {3'b010, 8'h05, 8'hFD, 16'h0010, 16'h0000, 16'h0001},
        {3'b010, 8'h7F, 8'h7F, 16'hC0FF, 16'h0000, 16'h0000}
    };

    function automatic logic [15:0] m_prod(input logic [7:0] a, input logic [7:0] b);
        logic signed [15:0] sa, sb;
        sa = 16'(signed'(a));
        sb = 16'(signed'(b));
        return 16'(sa * sb);
    endfunction

    function automatic logic [15:0] m_result(input logic [2:0] o, input logic [7:0] a,
        input logic [7:0] b, input logic [15:0] ad, input logic [15:0] ca, input logic [15:0] r);
        case (o)
            3'b000: return m_prod(a, b);
            3'b001: return ad + ca;
            3'b010: return m_prod(a, b) + ad;
            3'b011: return m_prod(a, b);
            3'b100: return ad + ca;
            3'b101: return r + m_prod(a, b);
            3'b110: return r;
            default: return 16'h0000;
        endcase
    endfunction

    function automatic logic [15:0] m_next(input logic [2:0] o, input logic [15:0] res,
        input logic e, input logic rs, input logic [15:0] r);
        if (rs) return 16'h0000;
        if (!e) return r;
        case (o)
            3'b011, 3'b100, 3'b101: return res;
            3'b111: return 16'h0000;
            default: return r;
        endcase
    endfunction

    function automatic string op_tag(input logic [2:0] o);
        case (o)
            3'b000: return "R2";
            3'b001: return "R3";
            3'b010: return "R4";
            3'b011: return "R5";
            3'b100: return "R6";
            3'b101: return "R7";
            3'b110: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic check(input string tag, input string what, input logic [15:0] act,
                         input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // one clock: drive at negedge, check result, then check register after the edge
    task automatic cycle(input logic [2:0] o, input logic [7:0] a, input logic [7:0] b,
        input logic [15:0] ad, input logic [15:0] ca, input logic e, input logic rs,
        input string tag);
        logic [15:0] exp_res;
        @(negedge clk);
        op = o; a_in = a; b_in = b; addend = ad; cascade_in = ca; ce = e; rst = rs;
        #1;
        exp_res = m_result(o, a, b, ad, ca, reg_m);
        check(tag, "result", result, exp_res);
        reg_m = m_next(o, exp_res, e, rs, reg_m);
        @(posedge clk);
        #1;
        check(tag, "reg_out", reg_out, reg_m);
    endtask

    initial begin
        #(8 * 50000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R11: register is zero out of reset
        repeat (3) @(posedge clk);
        #1;
        check("R11", "reset reg_out", reg_out, 16'h0000);
        reg_m = 16'h0000;

        // table walk, combinational modes (R1 signed products)
        for (int i = 0; i < 8; i++) begin
            logic [66:0] v;
            v = VEC[i];
            cycle(v[66:64], v[63:56], v[55:48], v[47:32], v[31:16], 1'b1, 1'b0,
                  op_tag(v[66:64]));
            check("R1", "table result", result, v[15:0]);
        end

        // R5 load product
        cycle(3'b011, 8'h06, 8'h07, 16'h0, 16'h0, 1'b1, 1'b0, "R5");
        check("R5", "loaded product", reg_out, 16'h002A);
        // R6 load sum
        cycle(3'b100, 8'h00, 8'h00, 16'hFFFF, 16'h0000, 1'b1, 1'b0, "R6");
        check("R6", "loaded sum", reg_out, 16'hFFFF);
        // R7 accumulate wraps past 0xFFFF
        cycle(3'b101, 8'h01, 8'h01, 16'h0, 16'h0, 1'b1, 1'b0, "R7");
        check("R7", "wrap to zero", reg_out, 16'h0000);
        cycle(3'b101, 8'hFE, 8'h03, 16'h0, 16'h0, 1'b1, 1'b0, "R7");
        check("R7", "negative accumulate", reg_out, 16'hFFFA);
        // R8 hold shows register
        cycle(3'b110, 8'h55, 8'h55, 16'h1111, 16'h2222, 1'b1, 1'b0, "R8");
        check("R8", "hold value", reg_out, 16'hFFFA);
        // R12 ce low: register held, result follows
        cycle(3'b101, 8'h02, 8'h02, 16'h0, 16'h0, 1'b0, 1'b0, "R12");
        check("R12", "result with ce low", result, 16'hFFFE);
        check("R12", "register held", reg_out, 16'hFFFA);
        cycle(3'b111, 8'h00, 8'h00, 16'h0, 16'h0, 1'b0, 1'b0, "R12");
        check("R12", "clear blocked", reg_out, 16'hFFFA);
        // R9 clear
        cycle(3'b111, 8'h12, 8'h34, 16'h5, 16'h6, 1'b1, 1'b0, "R9");
        check("R9", "cleared", reg_out, 16'h0000);
        // R11 reset beats a load
        cycle(3'b100, 8'h00, 8'h00, 16'h0005, 16'h0000, 1'b1, 1'b0, "R6");
        cycle(3'b011, 8'h03, 8'h03, 16'h0, 16'h0, 1'b1, 1'b1, "R11");
        check("R11", "reset priority", reg_out, 16'h0000);

        // R10: opcode changes every cycle, random operands
        for (int k = 0; k < 400; k++) begin
            logic [2:0] o;
            o = 3'((k * 5 + int'($urandom_range(0, 1))) % 8);
            cycle(o, 8'($urandom), 8'($urandom), 16'($urandom), 16'($urandom),
                  ($urandom_range(0, 7) != 0), ($urandom_range(0, 31) == 0), "R10");
        end

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule